// File: doc/BRIEF.md
# Command descriptor ring prefetcher

This block sits between host software and a descriptor parser. Software places command descriptors in a ring in memory. It tells the block how many words are ready by adding to a prepared count. The block keeps a processed pointer into the ring. Once the local descriptor FIFO has enough free space, it issues one DMA read for the next block of words and pushes the returned words into the FIFO, in order, toward the parser.

Fetching works on whole blocks. A request goes out only when the FIFO free space has reached a programmable threshold. Its length is limited by three things: the fetch size, the words left before the ring end, and the prepared count. A single burst therefore never crosses the end of the ring. Descriptors are laid out at a stride that may be larger than the descriptor length. Words in the gap between descriptors are discarded and never reach the FIFO. Software programs all of this through a small word-wide register port and can clear the counters and rewind the pointer.

Top module: `cmdring_prefetch`

## Requirements
- R1: After reset no DMA request is pending, the FIFO is empty, and the prepared count, processed count, pointer, configuration and status all read as zero.
- R2: The configuration register (address 0) holds the fetch size in bits [15:0] and the free-space threshold in bits [31:16]. While this register is zero, no DMA request is issued.
- R3: A request is raised only when all of these hold: the block is enabled, the prepared count is non-zero, FIFO free space is at least the threshold, and no earlier request or its data is outstanding. Once raised, the request stays asserted with a stable length and address until it is accepted.
- R4: The request length is the smallest of three values: the fetch size, (ring size − pointer), and the prepared count. The request address is ({base high (address 6), base low (address 5)}) + 4 × pointer.
- R5: After the last data word of a request arrives, three updates happen. The pointer advances by the length and becomes 0 when it reaches the ring size (address 7, in words). The prepared count drops by the length. The processed count rises by the length.
- R6: A write to the prepared count (address 2) clears it when bit 31 is 1; otherwise it adds bits [15:0]. A write to the processed count (address 3) clears it when bit 31 is 1 and is otherwise ignored.
- R7: A write to the pointer register (address 4) loads the pointer, so a write of 0 returns it to the ring start.
- R8: The descriptor register (address 1) holds the length in bits [7:0], the stride in bits [23:16] and an extra-token flag in bit 30, and reads back as written. Returned words at offset length or more within each stride are discarded. A stride of 0 keeps every word.
- R9: The status register (address 8) has five sticky bits. Bit 0 is block done, bit 1 is pointer wrapped, bit 2 is prepared count reached zero, bit 3 is a word dropped because the FIFO was full, and bit 4 is data that arrived with no request outstanding. Writing 1 to a bit clears it. Stray data is never pushed.
- R10: The FIFO delivers the kept words in arrival order, first word falling through, and pops on valid and ready.
- R11: A register read returns the addressed value on `reg_rdata` one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for writes and reads |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| dma_req_valid | output | 1 | DMA read request valid |
| dma_req_ready | input | 1 | DMA read request accepted |
| dma_req_addr | output | 64 | Byte address of the first word |
| dma_req_len | output | 16 | Number of words requested |
| dma_rd_valid | input | 1 | Returned data word valid |
| dma_rd_data | input | DATA_W | Returned data word |
| fifo_valid | output | 1 | Descriptor word available |
| fifo_ready | input | 1 | Parser takes the word |
| fifo_data | output | DATA_W | Descriptor word |

## Verification
The bench targets the places where the length choice and the ring bookkeeping meet. One burst is clipped by the ring end and must leave the pointer at zero; a design that skipped the clip would read past the ring, and one that wrapped wrong would leave the pointer at the ring size. Other bursts are clipped by a small prepared count or start from a rewound pointer near the ring end. A threshold case fills the FIFO halfway and expects silence until the FIFO is drained; a design that compared against fill level instead of free space would issue early. A stride case, an overflowing burst and stray data check that only the kept words reach the FIFO, in order, with the right status bits set; a design that pushed gap words or stray words would show surplus words in the drained FIFO.

// File: rtl/cmdring_pkg.sv
`timescale 1ns/1ps
package cmdring_pkg;
  localparam int REG_W  = 32;
  localparam int REG_AW = 4;
  localparam int CNT_W  = 16;
  localparam int ADDR_W = 64;
  localparam int ST_W   = 5;

  localparam logic [REG_AW-1:0] A_CFG  = 4'd0;
  localparam logic [REG_AW-1:0] A_DSZ  = 4'd1;
  localparam logic [REG_AW-1:0] A_PREP = 4'd2;
  localparam logic [REG_AW-1:0] A_PROC = 4'd3;
  localparam logic [REG_AW-1:0] A_PTR  = 4'd4;
  localparam logic [REG_AW-1:0] A_BLO  = 4'd5;
  localparam logic [REG_AW-1:0] A_BHI  = 4'd6;
  localparam logic [REG_AW-1:0] A_RING = 4'd7;
  localparam logic [REG_AW-1:0] A_STAT = 4'd8;

  localparam int ST_DONE  = 0;
  localparam int ST_WRAP  = 1;
  localparam int ST_EMPTY = 2;
  localparam int ST_DROP  = 3;
  localparam int ST_STRAY = 4;

  typedef enum logic [1:0] {F_IDLE, F_REQ, F_DATA} fetch_state_t;
endpackage

// File: rtl/cmdring_regs.sv
`timescale 1ns/1ps
module cmdring_regs
  import cmdring_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  input  logic              done_i,
  input  logic [CNT_W-1:0]  len_i,
  input  logic              drop_i,
  input  logic              stray_i,
  output logic [CNT_W-1:0]  fsize_o,
  output logic [CNT_W-1:0]  thr_o,
  output logic [CNT_W-1:0]  ptr_o,
  output logic [CNT_W-1:0]  prep_o,
  output logic [CNT_W-1:0]  ring_o,
  output logic [7:0]        dsize_o,
  output logic [7:0]        stride_o,
  output logic [ADDR_W-1:0] base_o,
  output logic              enable_o,
  output logic              restart_o
);
  logic [REG_W-1:0] cfg, base_lo, base_hi;
  logic             tok;
  logic [CNT_W-1:0] proc_cnt;
  logic [ST_W-1:0]  stat, ev;
  logic [CNT_W:0]   sum;
  logic             wraps;
  logic wr_cfg, wr_dsz, wr_prep, wr_proc, wr_ptr, wr_blo, wr_bhi, wr_ring, wr_stat;

  assign wr_cfg  = wr_en && (addr == A_CFG);
  assign wr_dsz  = wr_en && (addr == A_DSZ);
  assign wr_prep = wr_en && (addr == A_PREP);
  assign wr_proc = wr_en && (addr == A_PROC);
  assign wr_ptr  = wr_en && (addr == A_PTR);
  assign wr_blo  = wr_en && (addr == A_BLO);
  assign wr_bhi  = wr_en && (addr == A_BHI);
  assign wr_ring = wr_en && (addr == A_RING);
  assign wr_stat = wr_en && (addr == A_STAT);

  assign fsize_o  = cfg[CNT_W-1:0];
  assign thr_o    = cfg[REG_W-1:CNT_W];
  assign enable_o = (cfg != '0);
  assign base_o   = {base_hi, base_lo};

  assign sum       = {1'b0, ptr_o} + {1'b0, len_i};
  assign wraps     = done_i && (sum >= {1'b0, ring_o});
  assign restart_o = wr_ptr || wraps;

  always_comb begin
    ev           = '0;
    ev[ST_DONE]  = done_i;
    ev[ST_WRAP]  = wraps;
    ev[ST_EMPTY] = done_i && !wr_prep && (prep_o == len_i);
    ev[ST_DROP]  = drop_i;
    ev[ST_STRAY] = stray_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0; base_lo <= '0; base_hi <= '0; tok <= 1'b0;
      dsize_o <= '0; stride_o <= '0; ring_o <= '0; ptr_o <= '0;
      prep_o <= '0; proc_cnt <= '0; stat <= '0; rdata <= '0;
    end else begin
      if (wr_cfg)  cfg <= wdata;
      if (wr_blo)  base_lo <= wdata;
      if (wr_bhi)  base_hi <= wdata;
      if (wr_ring) ring_o <= wdata[CNT_W-1:0];
      if (wr_dsz) begin
        dsize_o  <= wdata[7:0];
        stride_o <= wdata[23:16];
        tok      <= wdata[30];
      end
      if (wr_ptr)      ptr_o <= wdata[CNT_W-1:0];
      else if (done_i) ptr_o <= wraps ? '0 : sum[CNT_W-1:0];
      if (wr_prep)     prep_o <= wdata[31] ? '0 : prep_o + wdata[CNT_W-1:0];
      else if (done_i) prep_o <= prep_o - len_i;
      if (wr_proc) begin
        if (wdata[31]) proc_cnt <= '0;
      end else if (done_i) begin
        proc_cnt <= proc_cnt + len_i;
      end
      stat <= (wr_stat ? (stat & ~wdata[ST_W-1:0]) : stat) | ev;
      case (addr)
        A_CFG:   rdata <= cfg;
        A_DSZ:   rdata <= {1'b0, tok, 6'b0, stride_o, 8'b0, dsize_o};
        A_PREP:  rdata <= REG_W'(prep_o);
        A_PROC:  rdata <= REG_W'(proc_cnt);
        A_PTR:   rdata <= REG_W'(ptr_o);
        A_BLO:   rdata <= base_lo;
        A_BHI:   rdata <= base_hi;
        A_RING:  rdata <= REG_W'(ring_o);
        A_STAT:  rdata <= REG_W'(stat);
        default: rdata <= '0;
      endcase
    end
  end

  // R5: a finished burst that reaches the ring end rewinds the pointer
  p_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    (done_i && !wr_en && (({1'b0, ptr_o} + {1'b0, len_i}) >= {1'b0, ring_o})) |=> (ptr_o == '0));

  // R5: the prepared count drops by exactly the fetched length
  p_prep_r5: assert property (@(posedge clk) disable iff (rst)
    (done_i && !wr_en) |=> (prep_o == $past(prep_o) - $past(len_i)));
endmodule

// File: rtl/cmdring_fetch.sv
`timescale 1ns/1ps
module cmdring_fetch
  import cmdring_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int FREE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable_i,
  input  logic [CNT_W-1:0]  fsize_i,
  input  logic [CNT_W-1:0]  thr_i,
  input  logic [CNT_W-1:0]  ptr_i,
  input  logic [CNT_W-1:0]  prep_i,
  input  logic [CNT_W-1:0]  ring_i,
  input  logic [7:0]        dsize_i,
  input  logic [7:0]        stride_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              restart_i,
  input  logic [FREE_W-1:0] free_i,
  input  logic              full_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [CNT_W-1:0]  req_len_o,
  input  logic              rd_valid_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              push_o,
  output logic [DATA_W-1:0] push_data_o,
  output logic              done_o,
  output logic              drop_o,
  output logic              stray_o
);
  fetch_state_t     state;
  logic [CNT_W-1:0] left, lim, want, remain, free_ext;
  logic [7:0]       pos;
  logic             go, keep, in_data;

  always_comb begin
    left     = (ptr_i < ring_i) ? (ring_i - ptr_i) : '0;
    lim      = (fsize_i < left) ? fsize_i : left;
    want     = (lim < prep_i) ? lim : prep_i;
    free_ext = CNT_W'(free_i);
    go       = enable_i && (prep_i != '0) && (want != '0) && (free_ext >= thr_i) && !done_o;
  end

  assign in_data     = (state == F_DATA);
  assign keep        = (stride_i == '0) || (pos < dsize_i);
  assign push_o      = rd_valid_i && in_data && keep && !full_i;
  assign drop_o      = rd_valid_i && in_data && keep && full_i;
  assign stray_o     = rd_valid_i && !in_data;
  assign push_data_o = rd_data_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= F_IDLE; req_valid_o <= 1'b0; req_addr_o <= '0;
      req_len_o <= '0; remain <= '0; done_o <= 1'b0; pos <= '0;
    end else begin
      done_o <= 1'b0;
      case (state)
        F_IDLE: if (go) begin
          req_valid_o <= 1'b1;
          req_len_o   <= want;
          req_addr_o  <= base_i + (ADDR_W'(ptr_i) << 2);
          state       <= F_REQ;
        end
        F_REQ: if (req_ready_i) begin
          req_valid_o <= 1'b0;
          remain      <= req_len_o;
          state       <= F_DATA;
        end
        F_DATA: if (rd_valid_i) begin
          remain <= remain - 1'b1;
          if (stride_i != '0) pos <= ((pos + 8'd1) == stride_i) ? '0 : pos + 8'd1;
          if (remain == CNT_W'(1)) begin
            done_o <= 1'b1;
            state  <= F_IDLE;
          end
        end
        default: state <= F_IDLE;
      endcase
      if (restart_i) pos <= '0;
    end
  end

  // R3: a pending request holds its fields until accepted
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_len_o) && $stable(req_addr_o)));

  // R3: a new request only follows a cycle with enough free space
  p_thr_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(req_valid_o) |-> $past(free_ext >= thr_i));

  // R4: length never exceeds fetch size or prepared count
  p_len_r4: assert property (@(posedge clk) disable iff (rst)
    req_valid_o |-> ((req_len_o != '0) && (req_len_o <= fsize_i) && (req_len_o <= prep_i)));
endmodule

// File: rtl/cmdring_fifo.sv
`timescale 1ns/1ps
module cmdring_fifo #(
  parameter int DEPTH  = 16,
  parameter int W      = 32,
  parameter int FREE_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_i,
  input  logic [W-1:0]      data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [W-1:0]      out_data_o,
  output logic [FREE_W-1:0] free_o,
  output logic              full_o
);
  localparam int AW = $clog2(DEPTH);
  logic [W-1:0]    mem [DEPTH];
  logic [AW-1:0]   wr_ptr, rd_ptr;
  logic [FREE_W-1:0] count;
  logic            do_push, do_pop;

  assign full_o      = (count == FREE_W'(DEPTH));
  assign free_o      = FREE_W'(DEPTH) - count;
  assign out_valid_o = (count != '0);
  assign out_data_o  = mem[rd_ptr];
  assign do_push     = push_i && !full_o;
  assign do_pop      = out_ready_i && out_valid_o;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= data_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0; rd_ptr <= '0; count <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      count <= count + FREE_W'(do_push) - FREE_W'(do_pop);
    end
  end

  // R10: a pop without a push lowers the fill level by one
  p_pop_r10: assert property (@(posedge clk) disable iff (rst)
    (out_ready_i && out_valid_o && !push_i) |=> (count == $past(count) - 1'b1));
endmodule

// File: rtl/cmdring_prefetch.sv
`timescale 1ns/1ps
module cmdring_prefetch
  import cmdring_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              dma_req_valid,
  input  logic              dma_req_ready,
  output logic [ADDR_W-1:0] dma_req_addr,
  output logic [CNT_W-1:0]  dma_req_len,
  input  logic              dma_rd_valid,
  input  logic [DATA_W-1:0] dma_rd_data,
  output logic              fifo_valid,
  input  logic              fifo_ready,
  output logic [DATA_W-1:0] fifo_data
);
  localparam int FREE_W = $clog2(FIFO_DEPTH) + 1;

  logic [CNT_W-1:0]  fsize, thr, ptr, prep, ring;
  logic [7:0]        dsize, stride;
  logic [ADDR_W-1:0] base;
  logic              enable, restart, done, drop, stray, push, full;
  logic [DATA_W-1:0] push_data;
  logic [FREE_W-1:0] free;

  cmdring_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .done_i(done), .len_i(dma_req_len), .drop_i(drop),
    .stray_i(stray), .fsize_o(fsize), .thr_o(thr), .ptr_o(ptr), .prep_o(prep),
    .ring_o(ring), .dsize_o(dsize), .stride_o(stride), .base_o(base),
    .enable_o(enable), .restart_o(restart)
  );

  cmdring_fetch #(.DATA_W(DATA_W), .FREE_W(FREE_W)) u_fetch (
    .clk(clk), .rst(rst), .enable_i(enable), .fsize_i(fsize), .thr_i(thr),
    .ptr_i(ptr), .prep_i(prep), .ring_i(ring), .dsize_i(dsize), .stride_i(stride),
    .base_i(base), .restart_i(restart), .free_i(free), .full_i(full),
    .req_valid_o(dma_req_valid), .req_ready_i(dma_req_ready),
    .req_addr_o(dma_req_addr), .req_len_o(dma_req_len),
    .rd_valid_i(dma_rd_valid), .rd_data_i(dma_rd_data), .push_o(push),
    .push_data_o(push_data), .done_o(done), .drop_o(drop), .stray_o(stray)
  );

  cmdring_fifo #(.DEPTH(FIFO_DEPTH), .W(DATA_W), .FREE_W(FREE_W)) u_fifo (
    .clk(clk), .rst(rst), .push_i(push), .data_i(push_data),
    .out_valid_o(fifo_valid), .out_ready_i(fifo_ready), .out_data_o(fifo_data),
    .free_o(free), .full_o(full)
  );
endmodule

// File: tb/cmdring_prefetch_tb.sv
`timescale 1ns/1ps
module cmdring_prefetch_tb;
  import cmdring_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        dma_req_valid;
  logic        dma_req_ready = 1'b0;
  logic [63:0] dma_req_addr;
  logic [15:0] dma_req_len;
  logic        dma_rd_valid = 1'b0;
  logic [31:0] dma_rd_data = '0;
  logic        fifo_valid;
  logic        fifo_ready = 1'b0;
  logic [31:0] fifo_data;

  always #2 clk = ~clk;

  cmdring_prefetch u_dut (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dma_req_valid(dma_req_valid),
    .dma_req_ready(dma_req_ready), .dma_req_addr(dma_req_addr),
    .dma_req_len(dma_req_len), .dma_rd_valid(dma_rd_valid),
    .dma_rd_data(dma_rd_data), .fifo_valid(fifo_valid), .fifo_ready(fifo_ready),
    .fifo_data(fifo_data)
  );

  localparam logic [63:0] BASE = 64'h0000_0001_0000_1000;
  // each row: fetch size, ring size, prepared words, expected length, expected pointer
  localparam logic [79:0] VECS [5] = '{
    {16'd4,  16'd32, 16'd10, 16'd4,  16'd4},
    {16'd8,  16'd6,  16'd10, 16'd6,  16'd0},
    {16'd8,  16'd32, 16'd3,  16'd3,  16'd3},
    {16'd5,  16'd5,  16'd5,  16'd5,  16'd0},
    {16'd16, 16'd32, 16'd20, 16'd16, 16'd16}
  };

  int checks = 0;
  int failures = 0;
  logic [31:0] exp_mem [256];
  int exp_wr = 0;
  int exp_rd = 0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic handshake(output bit got, output logic [15:0] len, output logic [63:0] addr);
    got = 1'b0; len = '0; addr = '0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (dma_req_valid) begin got = 1'b1; break; end
    end
    if (got) begin
      len = dma_req_len; addr = dma_req_addr;
      dma_req_ready = 1'b1;
      @(negedge clk);
      dma_req_ready = 1'b0;
    end
  endtask

  task automatic send(input logic [15:0] len, input logic [63:0] addr, input int dsz, input int strd);
    int base_idx;
    base_idx = int'((addr - BASE) >> 2);
    for (int i = 0; i < int'(len); i++) begin
      dma_rd_valid = 1'b1;
      dma_rd_data  = 32'hD000_0000 + 32'(base_idx + i);
      if ((strd == 0 || (i % strd) < dsz) && (exp_wr - exp_rd) < 16) begin
        exp_mem[exp_wr % 256] = dma_rd_data;
        exp_wr++;
      end
      @(negedge clk);
    end
    dma_rd_valid = 1'b0;
  endtask

  task automatic drain(input string tag);
    for (int k = 0; k < 64; k++) begin
      if (!fifo_valid) break;
      check(exp_rd < exp_wr && fifo_data == exp_mem[exp_rd % 256], tag, 64'(fifo_data), 64'(exp_mem[exp_rd % 256]));
      fifo_ready = 1'b1;
      @(negedge clk);
      fifo_ready = 1'b0;
      exp_rd++;
    end
    check(exp_rd == exp_wr, tag, 64'(exp_rd), 64'(exp_wr));
    exp_rd = exp_wr;
  endtask

  task automatic configure(input logic [15:0] fsize, input logic [15:0] thr, input logic [15:0] ring,
                           input logic [15:0] prep, input logic [15:0] ptr);
    wr(A_CFG, 32'h0);
    wr(A_PREP, 32'h8000_0000);
    wr(A_PROC, 32'h8000_0000);
    wr(A_PTR, 32'(ptr));
    wr(A_RING, 32'(ring));
    wr(A_STAT, 32'h1F);
    wr(A_PREP, 32'(prep));
    wr(A_CFG, {thr, fsize});
  endtask

  initial begin
    #600000;
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [15:0] len;
    logic [63:0] addr;
    bit got;
    bit seen;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(!dma_req_valid, "R1 req idle", 64'(dma_req_valid), 0);
    check(!fifo_valid, "R1 fifo empty", 64'(fifo_valid), 0);
    rd(A_PREP, r); check(r == 0, "R1 prep", 64'(r), 0);
    rd(A_PTR, r);  check(r == 0, "R1 ptr", 64'(r), 0);
    rd(A_STAT, r); check(r == 0, "R1 status", 64'(r), 0);
    rd(A_CFG, r);  check(r == 0, "R1 cfg", 64'(r), 0);
    // R11 readback one cycle after address
    wr(A_BLO, BASE[31:0]);
    wr(A_BHI, BASE[63:32]);
    rd(A_BLO, r); check(r == BASE[31:0], "R11 base low", 64'(r), 64'(BASE[31:0]));

    // vector walk: R3 R4 R5 R9 R10
    for (int v = 0; v < 5; v++) begin
      logic [15:0] f, rg, pp, el, ep;
      {f, rg, pp, el, ep} = VECS[v];
      configure(f, 16'd1, rg, pp, 16'd0);
      handshake(got, len, addr);
      wr(A_CFG, 32'h0);
      if (got) send(len, addr, 0, 0);
      repeat (2) @(negedge clk);
      check(got, "R3 request issued", 64'(got), 1);
      check(len == el, "R4 length", 64'(len), 64'(el));
      check(addr == BASE, "R4 address", addr, BASE);
      rd(A_PTR, r);  check(r == 32'(ep), "R5 pointer", 64'(r), 64'(ep));
      rd(A_PREP, r); check(r == 32'(pp - el), "R5 prepared", 64'(r), 64'(pp - el));
      rd(A_PROC, r); check(r == 32'(el), "R5 processed", 64'(r), 64'(el));
      rd(A_STAT, r);
      check(r[0] == 1'b1, "R9 done bit", 64'(r), 1);
      check(r[1] == (ep == 0), "R9 wrap bit", 64'(r[1]), 64'(ep == 0));
      drain("R10 fifo order");
    end

    // R6 counter writes, R2 disabled block stays idle
    rd(A_PROC, r); check(r == 16, "R6 proc before", 64'(r), 16);
    wr(A_PROC, 32'd5);
    rd(A_PROC, r); check(r == 16, "R6 proc plain write ignored", 64'(r), 16);
    wr(A_PROC, 32'h8000_0000);
    rd(A_PROC, r); check(r == 0, "R6 proc cleared", 64'(r), 0);
    wr(A_PREP, 32'h8000_0000);
    wr(A_PTR, 32'h0);
    wr(A_PREP, 32'd3);
    wr(A_PREP, 32'd4);
    seen = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (dma_req_valid) seen = 1'b1;
    end
    check(!seen, "R2 zero config no request", 64'(seen), 0);
    rd(A_PREP, r); check(r == 7, "R6 prep accumulates", 64'(r), 7);
    wr(A_PREP, 32'h8000_0000);
    rd(A_PREP, r); check(r == 0, "R6 prep cleared", 64'(r), 0);

    // R3 threshold gating
    configure(16'd8, 16'd12, 16'd32, 16'd16, 16'd0);
    handshake(got, len, addr);
    if (got) send(len, addr, 0, 0);
    seen = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (dma_req_valid) seen = 1'b1;
    end
    check(!seen, "R3 free below threshold", 64'(seen), 0);
    drain("R10 threshold drain");
    handshake(got, len, addr);
    wr(A_CFG, 32'h0);
    check(got && len == 8, "R3 request after drain", 64'(len), 8);
    if (got) send(len, addr, 0, 0);
    repeat (2) @(negedge clk);
    rd(A_STAT, r); check(r[2] == 1'b1, "R9 prepared empty bit", 64'(r), 4);
    rd(A_PTR, r);  check(r == 16, "R5 pointer two blocks", 64'(r), 16);
    drain("R10 second block");

    // R8 stride filter
    wr(A_DSZ, 32'h4004_0002);
    rd(A_DSZ, r); check(r == 32'h4004_0002, "R8 descriptor readback", 64'(r), 64'h4004_0002);
    configure(16'd8, 16'd1, 16'd32, 16'd8, 16'd0);
    handshake(got, len, addr);
    wr(A_CFG, 32'h0);
    if (got) send(len, addr, 2, 4);
    repeat (2) @(negedge clk);
    rd(A_PTR, r); check(r == 8, "R8 pointer counts gap words", 64'(r), 8);
    drain("R8 kept words only");
    wr(A_DSZ, 32'h0);

    // R9 drop on full FIFO
    configure(16'd12, 16'd1, 16'd32, 16'd20, 16'd0);
    handshake(got, len, addr);
    if (got) send(len, addr, 0, 0);
    handshake(got, len, addr);
    wr(A_CFG, 32'h0);
    check(got && len == 8, "R4 length limited by prepared", 64'(len), 8);
    if (got) send(len, addr, 0, 0);
    repeat (2) @(negedge clk);
    rd(A_STAT, r); check(r[3] == 1'b1, "R9 drop bit", 64'(r), 8);
    drain("R9 only fitting words kept");

    // R7 pointer load, R4 clip at ring end
    configure(16'd8, 16'd1, 16'd32, 16'd10, 16'd30);
    handshake(got, len, addr);
    wr(A_CFG, 32'h0);
    check(got && len == 2, "R4 clip at ring end", 64'(len), 2);
    check(addr == BASE + 64'd120, "R7 address from loaded pointer", addr, BASE + 64'd120);
    if (got) send(len, addr, 0, 0);
    repeat (2) @(negedge clk);
    rd(A_PTR, r);  check(r == 0, "R5 wrap to start", 64'(r), 0);
    rd(A_STAT, r); check(r[1] == 1'b1, "R9 wrap bit set", 64'(r), 2);
    drain("R10 wrap burst");

    // R9 stray data and write-one-to-clear
    wr(A_STAT, 32'h1F);
    @(negedge clk);
    dma_rd_valid = 1'b1; dma_rd_data = 32'hBAD0_0001;
    @(negedge clk);
    dma_rd_valid = 1'b0;
    repeat (2) @(negedge clk);
    check(!fifo_valid, "R9 stray not pushed", 64'(fifo_valid), 0);
    rd(A_STAT, r); check(r == 32'h10, "R9 stray bit", 64'(r), 64'h10);
    wr(A_STAT, 32'h10);
    rd(A_STAT, r); check(r == 0, "R9 write one clears", 64'(r), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule